// File: doc/BRIEF.md
# Repeated String Transfer Sequencer

This block carries out one block string operation over a byte-wide memory port. The operation can be a move, load, store, compare or scan, on byte or word elements. A caller loads the source offset, the destination offset, the count, two segment bases, the direction flag, the element size, the accumulator, the incoming zero flag and a repeat mode, then pulses `start`. The sequencer issues byte requests one at a time, waits for `memReady` on each, and steps the offsets after every element. When the operation ends it pulses `done`; the updated offsets, count, accumulator and zero flag are then valid on the outputs.

The repeat mode decides how many elements are handled. In single mode exactly one element is handled. In counted mode the count is tested and decremented before each element. In the two conditional modes, a compare or scan also stops on the zero flag. A word element is handled as two byte accesses, low byte first.

Top module: `strRepSeq`

## Requirements
- R1: After reset, and whenever `busy` is low, `memReq` and `done` are low.
- R2: A source byte is fetched at physical address `dsIn*16 + offset`, and a destination byte is read or written at `esIn*16 + offset`. The offset comes from the source and destination offset registers respectively, and the sum is 20 bits wide.
- R3: After each element an offset moves by 1 for bytes (`wordMode`=0) or by 2 for words (`wordMode`=1). It goes up when `dirFlag`=0 and down when `dirFlag`=1. Offset arithmetic, including the +1 for the high byte of a word, wraps modulo 2^16.
- R4: `opSel` encodes 0=move, 1=load, 2=store, 3=compare, 4=scan. Move and compare step both offsets, load steps only the source offset, and store and scan step only the destination offset.
- R5: A word element is transferred as two byte accesses: the low byte at the lower offset first, then the high byte at offset+1.
- R6: With `repSel`=1 (counted), the count is tested before every element. If it is zero, the operation ends with no memory access; otherwise it is decremented by one and the element is handled. The count never rises during an operation.
- R7: With `repSel`=0 (single), exactly one element is handled whatever the count holds, and the count is returned unchanged.
- R8: With `repSel`=2 (while equal) a compare or scan also stops after an element that clears the zero flag. With `repSel`=3 (while not equal) it also stops after an element that sets the zero flag. For move, load and store, modes 2 and 3 act as mode 1.
- R9: A compare sets `zfOut` when the source and destination elements are equal and clears it otherwise. A scan sets it when the destination element equals AL (byte) or AX (word). Move, load and store return `zfIn` unchanged.
- R10: A load writes the element into the accumulator: a byte replaces only bits 7:0 and keeps bits 15:8; a word replaces all 16 bits. A store writes accumulator bits 7:0, or bits 7:0 then 15:8 for a word.
- R11: Only one request is outstanding at a time. While `memReq` is high and `memReady` is low, `memReq`, `memAddr`, `memWe` and `memWdata` hold their values.
- R12: `done` is a one-cycle pulse, given while `busy` is high, and the results are valid on the outputs from that cycle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| opSel | input | 3 | Operation: 0 move, 1 load, 2 store, 3 compare, 4 scan |
| repSel | input | 2 | Repeat mode: 0 single, 1 counted, 2 while equal, 3 while not equal |
| wordMode | input | 1 | 1 = word elements, 0 = byte elements |
| dirFlag | input | 1 | 0 = offsets go up, 1 = offsets go down |
| siIn | input | 16 | Initial source offset |
| diIn | input | 16 | Initial destination offset |
| cxIn | input | 16 | Initial element count |
| dsIn | input | 16 | Source segment base |
| esIn | input | 16 | Destination segment base |
| accIn | input | 16 | Initial accumulator |
| zfIn | input | 1 | Initial zero flag |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write request, 0 = read request |
| memAddr | output | 20 | Physical byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, taken in the cycle `memReady` is high |
| memReady | input | 1 | Completes the pending request |
| siOut | output | 16 | Source offset |
| diOut | output | 16 | Destination offset |
| cxOut | output | 16 | Count |
| accOut | output | 16 | Accumulator |
| zfOut | output | 1 | Zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench checks the counted mode with a zero count, where a design that tests the count after the element instead of before would make one stray transfer. It also checks the single mode with a zero count, where a design that tested the count would skip the one element it owes. Both conditional modes are run against a mismatch and an early match, and the bench checks the exact count and offsets at the stop point; an off-by-one exit shows up as a wrong count. A word load placed across the 64K offset boundary, and a downward byte load from offset zero, expose a design that carries into the segment or fails to wrap. A word move under a stalling ready line checks that high and low bytes land in order and that a request is not dropped or duplicated while it waits.

// File: rtl/strSeqPkg.sv
package strSeqPkg;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_CMP   = 3'd3,
    OP_SCAN  = 3'd4
  } opKind_t;

  typedef enum logic [1:0] {
    RP_ONCE     = 2'd0,
    RP_COUNT    = 2'd1,
    RP_WHILE_EQ = 2'd2,
    RP_WHILE_NE = 2'd3
  } repKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the caller's operands
    logic cxDec;     // count down by one
    logic srcLatch;  // store memRdata into source buffer
    logic dstLatch;  // store memRdata into destination buffer
    logic useDst;    // address uses destination segment and offset
    logic byteHi;    // access targets the high byte of a word
    logic advance;   // element finished: step offsets, update acc/zf
  } ctrlStrobe_t;
endpackage

// File: rtl/strSeqPath.sv
module strSeqPath
  import strSeqPkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 ctl,
  input  opKind_t                     opIn,
  input  repKind_t                    repIn,
  input  logic                        wordIn,
  input  logic                        dirIn,
  input  logic [OFS_W-1:0]            siIn,
  input  logic [OFS_W-1:0]            diIn,
  input  logic [OFS_W-1:0]            cxIn,
  input  logic [OFS_W-1:0]            dsIn,
  input  logic [OFS_W-1:0]            esIn,
  input  logic [ACC_W-1:0]            accIn,
  input  logic                        zfIn,
  input  logic [BYTE_W-1:0]           memRdata,
  output logic [OFS_W+SEG_SHIFT-1:0]  memAddr,
  output logic [BYTE_W-1:0]           memWdata,
  output logic [OFS_W-1:0]            siOut,
  output logic [OFS_W-1:0]            diOut,
  output logic [OFS_W-1:0]            cxOut,
  output logic [ACC_W-1:0]            accOut,
  output logic                        zfOut,
  output opKind_t                     opCur,
  output repKind_t                    repCur,
  output logic                        wordCur,
  output logic                        cxZero,
  output logic                        elemEq
);
  localparam int PHYS_W = OFS_W + SEG_SHIFT;

  logic [OFS_W-1:0] siR, diR, cxR, dsR, esR;
  logic [ACC_W-1:0] accR, srcBuf, dstBuf;
  logic             zfR, dirR, wordR;
  opKind_t          opR;
  repKind_t         repR;

  logic [OFS_W-1:0] stepAmt, siNext, diNext, ofs, seg;
  logic [ACC_W-1:0] cmpRef;

  assign stepAmt = wordR ? OFS_W'(2) : OFS_W'(1);
  assign siNext  = dirR ? siR - stepAmt : siR + stepAmt;
  assign diNext  = dirR ? diR - stepAmt : diR + stepAmt;

  assign cmpRef = (opR == OP_SCAN) ? accR : srcBuf;
  assign elemEq = wordR ? (cmpRef == dstBuf)
                        : (cmpRef[BYTE_W-1:0] == dstBuf[BYTE_W-1:0]);
  assign cxZero = (cxR == '0);

  assign ofs     = (ctl.useDst ? diR : siR) + OFS_W'(ctl.byteHi);
  assign seg     = ctl.useDst ? esR : dsR;
  assign memAddr = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs};

  always_comb begin
    if (opR == OP_MOVE)
      memWdata = ctl.byteHi ? srcBuf[ACC_W-1:BYTE_W] : srcBuf[BYTE_W-1:0];
    else
      memWdata = ctl.byteHi ? accR[ACC_W-1:BYTE_W] : accR[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siR <= '0; diR <= '0; cxR <= '0; dsR <= '0; esR <= '0;
      accR <= '0; srcBuf <= '0; dstBuf <= '0;
      zfR <= 1'b0; dirR <= 1'b0; wordR <= 1'b0;
      opR <= OP_MOVE; repR <= RP_ONCE;
    end else if (ctl.capture) begin
      siR <= siIn; diR <= diIn; cxR <= cxIn; dsR <= dsIn; esR <= esIn;
      accR <= accIn; zfR <= zfIn; dirR <= dirIn; wordR <= wordIn;
      opR <= opIn; repR <= repIn;
    end else begin
      if (ctl.cxDec) cxR <= cxR - OFS_W'(1);
      if (ctl.srcLatch) begin
        if (ctl.byteHi) srcBuf[ACC_W-1:BYTE_W] <= memRdata;
        else            srcBuf[BYTE_W-1:0]     <= memRdata;
      end
      if (ctl.dstLatch) begin
        if (ctl.byteHi) dstBuf[ACC_W-1:BYTE_W] <= memRdata;
        else            dstBuf[BYTE_W-1:0]     <= memRdata;
      end
      if (ctl.advance) begin
        unique case (opR)
          OP_MOVE:  begin siR <= siNext; diR <= diNext; end
          OP_LOAD:  begin
            siR <= siNext;
            if (wordR) accR <= srcBuf;
            else       accR[BYTE_W-1:0] <= srcBuf[BYTE_W-1:0];
          end
          OP_STORE: diR <= diNext;
          OP_CMP:   begin siR <= siNext; diR <= diNext; zfR <= elemEq; end
          OP_SCAN:  begin diR <= diNext; zfR <= elemEq; end
          default:  ;
        endcase
      end
    end
  end

  assign siOut   = siR;
  assign diOut   = diR;
  assign cxOut   = cxR;
  assign accOut  = accR;
  assign zfOut   = zfR;
  assign opCur   = opR;
  assign repCur  = repR;
  assign wordCur = wordR;
endmodule

// File: rtl/strSeqCtrl.sv
module strSeqCtrl
  import strSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  opKind_t     opCur,
  input  repKind_t    repCur,
  input  logic        wordCur,
  input  logic        cxZero,
  input  logic        elemEq,
  input  logic        memReady,
  output ctrlStrobe_t ctl,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SRC, ST_DRD, ST_WR, ST_STEP, ST_DONE
  } state_t;

  state_t st, stNext;
  logic   hiR, hiNext;
  logic   lastByte, condStop;

  assign lastByte = !wordCur || hiR;
  assign condStop = ((opCur == OP_CMP) || (opCur == OP_SCAN)) &&
                    (((repCur == RP_WHILE_EQ) && !elemEq) ||
                     ((repCur == RP_WHILE_NE) &&  elemEq));

  always_comb begin
    ctl    = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    done   = 1'b0;
    stNext = st;
    hiNext = hiR;
    unique case (st)
      ST_IDLE: if (start) begin
        ctl.capture = 1'b1;
        stNext      = ST_CHECK;
      end
      ST_CHECK: begin
        if (repCur != RP_ONCE && cxZero) begin
          stNext = ST_DONE;
        end else begin
          ctl.cxDec = (repCur != RP_ONCE);
          hiNext    = 1'b0;
          unique case (opCur)
            OP_MOVE, OP_LOAD, OP_CMP: stNext = ST_SRC;
            OP_STORE:                 stNext = ST_WR;
            OP_SCAN:                  stNext = ST_DRD;
            default:                  stNext = ST_STEP;
          endcase
        end
      end
      ST_SRC: begin
        memReq     = 1'b1;
        ctl.byteHi = hiR;
        if (memReady) begin
          ctl.srcLatch = 1'b1;
          hiNext       = !lastByte;
          if (lastByte)
            stNext = (opCur == OP_MOVE) ? ST_WR :
                     (opCur == OP_CMP)  ? ST_DRD : ST_STEP;
        end
      end
      ST_DRD: begin
        memReq     = 1'b1;
        ctl.useDst = 1'b1;
        ctl.byteHi = hiR;
        if (memReady) begin
          ctl.dstLatch = 1'b1;
          hiNext       = !lastByte;
          if (lastByte) stNext = ST_STEP;
        end
      end
      ST_WR: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.useDst = 1'b1;
        ctl.byteHi = hiR;
        if (memReady) begin
          hiNext = !lastByte;
          if (lastByte) stNext = ST_STEP;
        end
      end
      ST_STEP: begin
        ctl.advance = 1'b1;
        stNext = (repCur == RP_ONCE || condStop) ? ST_DONE : ST_CHECK;
      end
      ST_DONE: begin
        done   = 1'b1;
        stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      hiR <= 1'b0;
    end else begin
      st  <= stNext;
      hiR <= hiNext;
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/strRepSeq.sv
module strRepSeq
  import strSeqPkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [2:0]                 opSel,
  input  logic [1:0]                 repSel,
  input  logic                       wordMode,
  input  logic                       dirFlag,
  input  logic [OFS_W-1:0]           siIn,
  input  logic [OFS_W-1:0]           diIn,
  input  logic [OFS_W-1:0]           cxIn,
  input  logic [OFS_W-1:0]           dsIn,
  input  logic [OFS_W-1:0]           esIn,
  input  logic [15:0]                accIn,
  input  logic                       zfIn,
  output logic                       memReq,
  output logic                       memWe,
  output logic [OFS_W+SEG_SHIFT-1:0] memAddr,
  output logic [7:0]                 memWdata,
  input  logic [7:0]                 memRdata,
  input  logic                       memReady,
  output logic [OFS_W-1:0]           siOut,
  output logic [OFS_W-1:0]           diOut,
  output logic [OFS_W-1:0]           cxOut,
  output logic [15:0]                accOut,
  output logic                       zfOut,
  output logic                       busy,
  output logic                       done
);
  ctrlStrobe_t ctl;
  opKind_t     opCur;
  repKind_t    repCur;
  logic        wordCur, cxZero, elemEq;

  strSeqPath #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .opIn(opKind_t'(opSel)), .repIn(repKind_t'(repSel)),
    .wordIn(wordMode), .dirIn(dirFlag),
    .siIn(siIn), .diIn(diIn), .cxIn(cxIn), .dsIn(dsIn), .esIn(esIn),
    .accIn(accIn), .zfIn(zfIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .siOut(siOut), .diOut(diOut), .cxOut(cxOut), .accOut(accOut), .zfOut(zfOut),
    .opCur(opCur), .repCur(repCur), .wordCur(wordCur),
    .cxZero(cxZero), .elemEq(elemEq)
  );

  strSeqCtrl ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .opCur(opCur), .repCur(repCur), .wordCur(wordCur),
    .cxZero(cxZero), .elemEq(elemEq), .memReady(memReady),
    .ctl(ctl), .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );
endmodule

// File: rtl/strRepSeqChk.sv
module strRepSeqChk #(
  parameter int OFS_W  = 16,
  parameter int PHYS_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [PHYS_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic [OFS_W-1:0]  cxOut,
  input logic              busy,
  input logic              done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !done)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)
                               && $stable(memWdata))); // R11

  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || cxOut <= $past(cxOut))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R12
endmodule

bind strRepSeq strRepSeqChk #(.OFS_W(OFS_W), .PHYS_W(OFS_W + SEG_SHIFT)) chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memReady(memReady),
  .memAddr(memAddr), .memWdata(memWdata), .cxOut(cxOut), .busy(busy), .done(done)
);

// File: tb/strRepSeq_test.sv
module strRepSeq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  repSel = '0;
  logic        wordMode = 1'b0, dirFlag = 1'b0, zfIn = 1'b0;
  logic [15:0] siIn = '0, diIn = '0, cxIn = '0, dsIn = '0, esIn = '0, accIn = '0;
  logic        memReq, memWe, memReady, busy, done, zfOut;
  logic [19:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic [15:0] siOut, diOut, cxOut, accOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  mem [0:4095];
  logic [19:0] wrLog [0:63];
  int          wrCnt = 0;
  int          hsCnt = 0;
  logic [19:0] rdLast = '0;
  logic        slowMode = 1'b0;
  logic        gate = 1'b0;

  always #10 clk = ~clk;

  strRepSeq uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .repSel(repSel),
    .wordMode(wordMode), .dirFlag(dirFlag), .siIn(siIn), .diIn(diIn),
    .cxIn(cxIn), .dsIn(dsIn), .esIn(esIn), .accIn(accIn), .zfIn(zfIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady),
    .siOut(siOut), .diOut(diOut), .cxOut(cxOut), .accOut(accOut),
    .zfOut(zfOut), .busy(busy), .done(done)
  );

  assign memReady = memReq && (!slowMode || gate);
  assign memRdata = mem[memAddr[11:0]];

  always @(posedge clk) begin
    gate <= ~gate;
    if (memReq && memReady) begin
      hsCnt <= hsCnt + 1;
      if (memWe) begin
        mem[memAddr[11:0]] <= memWdata;
        wrLog[wrCnt[5:0]]  <= memAddr;
        wrCnt <= wrCnt + 1;
      end else begin
        rdLast <= memAddr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic runOp(input logic [2:0] op, input logic [1:0] rp,
                       input logic wd, input logic dr,
                       input logic [15:0] si, input logic [15:0] di,
                       input logic [15:0] cx, input logic [15:0] ds,
                       input logic [15:0] es, input logic [15:0] acc,
                       input logic zf);
    int n;
    @(negedge clk);
    opSel = op; repSel = rp; wordMode = wd; dirFlag = dr;
    siIn = si; diIn = di; cxIn = cx; dsIn = ds; esIn = es; accIn = acc; zfIn = zf;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R12", "done pulse seen", {31'd0, done}, 32'd1);
  endtask

  task automatic tReset();
    chkEq("R1", "busy after reset", {31'd0, busy}, 32'd0);
    chkEq("R1", "memReq after reset", {31'd0, memReq}, 32'd0);
    chkEq("R1", "done after reset", {31'd0, done}, 32'd0);
  endtask

  task automatic tMoveByte();
    int w0;
    mem[12'h500] = 8'h38;
    w0 = wrCnt;
    runOp(3'd0, 2'd0, 1'b0, 1'b0, 16'h0500, 16'h0300, 16'h0009, 16'h2000, 16'h4000, 16'h0, 1'b0);
    chkEq("R2", "move destination address", {12'd0, wrLog[w0[5:0]]}, 32'h40300);
    chkEq("R2", "moved byte", {24'd0, mem[12'h300]}, 32'h38);
    chkEq("R3", "source offset", {16'd0, siOut}, 32'h0501);
    chkEq("R4", "destination offset", {16'd0, diOut}, 32'h0301);
    chkEq("R7", "count kept", {16'd0, cxOut}, 32'h0009);
    @(negedge clk);
    chkEq("R12", "done lasts one cycle", {31'd0, done}, 32'd0);
    chkEq("R12", "result held", {16'd0, siOut}, 32'h0501);
  endtask

  task automatic tRepWordDown();
    int w0;
    mem[12'h110] = 8'hA1; mem[12'h111] = 8'hA2;
    mem[12'h10E] = 8'hB1; mem[12'h10F] = 8'hB2;
    mem[12'h10C] = 8'hC1; mem[12'h10D] = 8'hC2;
    slowMode = 1'b1;
    w0 = wrCnt;
    runOp(3'd0, 2'd1, 1'b1, 1'b1, 16'h0110, 16'h0210, 16'd3, 16'h0, 16'h0, 16'h0, 1'b0);
    slowMode = 1'b0;
    chkEq("R5", "first write low byte", {12'd0, wrLog[w0[5:0]]}, 32'h00210);
    chkEq("R5", "second write high byte", {12'd0, wrLog[(w0 + 1) & 63]}, 32'h00211);
    chkEq("R6", "write count", wrCnt - w0, 32'd6);
    chkEq("R5", "word 1 low", {24'd0, mem[12'h210]}, 32'hA1);
    chkEq("R5", "word 3 high", {24'd0, mem[12'h20D]}, 32'hC2);
    chkEq("R3", "src after downward words", {16'd0, siOut}, 32'h010A);
    chkEq("R3", "dst after downward words", {16'd0, diOut}, 32'h020A);
    chkEq("R6", "count exhausted", {16'd0, cxOut}, 32'd0);
  endtask

  task automatic tRepZero();
    int h0;
    h0 = hsCnt;
    runOp(3'd0, 2'd1, 1'b0, 1'b0, 16'h0123, 16'h0456, 16'd0, 16'h0, 16'h0, 16'h0, 1'b0);
    chkEq("R6", "no access with zero count", hsCnt - h0, 32'd0);
    chkEq("R6", "src untouched", {16'd0, siOut}, 32'h0123);
    chkEq("R6", "dst untouched", {16'd0, diOut}, 32'h0456);
  endtask

  task automatic tLoad();
    mem[12'h400] = 8'h34; mem[12'h401] = 8'h12;
    runOp(3'd1, 2'd0, 1'b1, 1'b0, 16'h0400, 16'h0777, 16'd1, 16'h0, 16'h0, 16'h0, 1'b1);
    chkEq("R10", "word load", {16'd0, accOut}, 32'h1234);
    chkEq("R4", "load steps source", {16'd0, siOut}, 32'h0402);
    chkEq("R4", "load keeps dest", {16'd0, diOut}, 32'h0777);
    chkEq("R9", "load keeps zf", {31'd0, zfOut}, 32'd1);
  endtask

  task automatic tLoadByteWrap();
    mem[12'h000] = 8'h5E;
    runOp(3'd1, 2'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'd0, 16'h0, 16'h0, 16'hAB00, 1'b0);
    chkEq("R10", "byte load keeps high", {16'd0, accOut}, 32'hAB5E);
    chkEq("R3", "offset wraps down", {16'd0, siOut}, 32'hFFFF);
  endtask

  task automatic tLoadWordWrap();
    mem[12'h1FF] = 8'hCD; mem[12'h200] = 8'hAB;
    runOp(3'd1, 2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0, 16'd0, 16'h0020, 16'h0, 16'h0, 1'b0);
    chkEq("R3", "high byte offset wraps", {12'd0, rdLast}, 32'h00200);
    chkEq("R5", "word across boundary", {16'd0, accOut}, 32'hABCD);
    chkEq("R3", "offset wraps up", {16'd0, siOut}, 32'h0001);
  endtask

  task automatic tStoreRep();
    for (int i = 0; i < 4; i++) mem[12'h600 + i] = 8'h00;
    runOp(3'd2, 2'd1, 1'b0, 1'b0, 16'h0888, 16'h0600, 16'd4, 16'h0, 16'h0, 16'h125A, 1'b0);
    chkEq("R10", "store first", {24'd0, mem[12'h600]}, 32'h5A);
    chkEq("R10", "store last", {24'd0, mem[12'h603]}, 32'h5A);
    chkEq("R4", "store steps dest", {16'd0, diOut}, 32'h0604);
    chkEq("R4", "store keeps src", {16'd0, siOut}, 32'h0888);
  endtask

  task automatic tCmpWhileEq();
    mem[12'h700] = 8'h01; mem[12'h701] = 8'h02; mem[12'h702] = 8'h03; mem[12'h703] = 8'h04;
    mem[12'h800] = 8'h01; mem[12'h801] = 8'h02; mem[12'h802] = 8'h09; mem[12'h803] = 8'h04;
    runOp(3'd3, 2'd2, 1'b0, 1'b0, 16'h0700, 16'h0800, 16'd4, 16'h0, 16'h0, 16'h0, 1'b1);
    chkEq("R8", "while-equal stop count", {16'd0, cxOut}, 32'd1);
    chkEq("R8", "while-equal src", {16'd0, siOut}, 32'h0703);
    chkEq("R4", "compare steps dest", {16'd0, diOut}, 32'h0803);
    chkEq("R9", "mismatch clears zf", {31'd0, zfOut}, 32'd0);
  endtask

  task automatic tScanWhileNe();
    mem[12'h900] = 8'h11; mem[12'h901] = 8'h22; mem[12'h902] = 8'h33; mem[12'h903] = 8'h44;
    runOp(3'd4, 2'd3, 1'b0, 1'b0, 16'h0555, 16'h0900, 16'd10, 16'h0, 16'h0, 16'hFF33, 1'b0);
    chkEq("R8", "while-not-equal stop count", {16'd0, cxOut}, 32'd7);
    chkEq("R4", "scan steps dest", {16'd0, diOut}, 32'h0903);
    chkEq("R4", "scan keeps src", {16'd0, siOut}, 32'h0555);
    chkEq("R9", "scan match sets zf", {31'd0, zfOut}, 32'd1);
  endtask

  task automatic tScanExhaust();
    mem[12'hA00] = 8'h55; mem[12'hA01] = 8'h66;
    runOp(3'd4, 2'd3, 1'b0, 1'b0, 16'h0, 16'h0A00, 16'd2, 16'h0, 16'h0, 16'h0033, 1'b1);
    chkEq("R6", "scan runs out", {16'd0, cxOut}, 32'd0);
    chkEq("R9", "no match clears zf", {31'd0, zfOut}, 32'd0);
    chkEq("R8", "scan end dest", {16'd0, diOut}, 32'h0A02);
  endtask

  task automatic tOnceZeroCount();
    int h0;
    h0 = hsCnt;
    runOp(3'd2, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0B00, 16'd0, 16'h0, 16'h0, 16'h0077, 1'b0);
    chkEq("R7", "single mode ignores zero count", {24'd0, mem[12'hB00]}, 32'h77);
    chkEq("R7", "single mode one access", hsCnt - h0, 32'd1);
    chkEq("R7", "single mode count kept", {16'd0, cxOut}, 32'd0);
  endtask

  task automatic tCmpWordOnce();
    mem[12'hC00] = 8'h10; mem[12'hC01] = 8'h20;
    mem[12'hD00] = 8'h10; mem[12'hD01] = 8'h20;
    runOp(3'd3, 2'd0, 1'b1, 1'b0, 16'h0C00, 16'h0D00, 16'd5, 16'h0, 16'h0, 16'h0, 1'b0);
    chkEq("R9", "equal words set zf", {31'd0, zfOut}, 32'd1);
    chkEq("R4", "compare steps src", {16'd0, siOut}, 32'h0C02);
    chkEq("R7", "compare single count kept", {16'd0, cxOut}, 32'd5);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tMoveByte();
    tRepWordDown();
    tRepZero();
    tLoad();
    tLoadByteWrap();
    tLoadWordWrap();
    tStoreRep();
    tCmpWhileEq();
    tScanWhileNe();
    tScanExhaust();
    tOnceZeroCount();
    tCmpWordOnce();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule